// File: doc/BRIEF.md
# Stop-Clock Power Management Controller

This controller sits on the processor side and answers a stop-clock request from system logic. The request pin is active-low and may change at any time, so it first passes through a synchronizer. Once the synchronized request is seen, the controller does nothing until an instruction retirement boundary arrives. Only then does it take the request and start an ordered shutdown. The steps are: a one-cycle recognition, a pipeline flush, a wait until the bus is idle, and an acknowledge special bus cycle. Last, the internal clock enable is gated off once the cycle's ready and the write-buffer-empty condition have both been sampled. The write-buffer-empty condition can be masked.

From stop-grant, system logic may halt the bus clock, which the controller sees as a level input. This takes it into a deeper stop-clock state. Restarting the bus clock brings it back to stop-grant. When the request is withdrawn in stop-grant, the clock enable returns at once and instruction retirement restarts one cycle later.

If the request is withdrawn before it has been recognized, that is a protocol violation, and a sticky error flag is raised. Before the acknowledge cycle has started, the sequence is abandoned. Once the acknowledge cycle is on the bus, it is completed. The pipeline and the bus unit are outside the block. All of its pins are plain control and status levels. The special-cycle request is held high until its ready input has been sampled high, and a ready while no request is pending has no effect.

Top module: `stopclk_ctrl`

## Requirements
- R1: After reset the state code is 0 (run), the clock enable and retire enable are high, and the flush request, special-cycle request and error flag are low.
- R2: The active-low request passes through two synchronizer flops. Any low pulse that covers two rising clock edges is captured. The controller enters state 1 (recognized) only on an edge where the synchronized request is high and the retire-boundary strobe is high, and retire enable is low from then on.
- R3: State 2 (flush) follows recognition and holds the flush request high until flush-done is sampled high. Flush-done in any other state has no effect.
- R4: State 3 (drain) follows the flush and lasts until bus-idle is sampled high. Bus-idle during the flush does not shorten the sequence.
- R5: State 4 (acknowledge) follows the drain. The special-cycle request is high in it until the edge that samples ready high, and low after that edge.
- R6: The controller leaves state 4 for state 5 (stop-grant) on the first edge at which ready has been sampled (on that edge or an earlier one in the same state 4) and write-buffer-empty is high. The clock enable is low in states 5 and 6.
- R7: With the mask input high, the write-buffer-empty input is ignored and ready alone ends state 4.
- R8: In state 5, a high bus-clock-stopped input moves the controller to state 6 (stop-clock). The request is ignored in state 6. When that input goes low, the controller returns to state 5.
- R9: In state 5 with the request low and the bus clock running, the controller returns to state 0. The clock enable is high in that first cycle, and retire enable goes high one cycle later.
- R10: If the synchronized request goes low while it is pending in state 0, or in states 1 to 3, the error flag is set and the controller returns to state 0 with no special cycle. If it goes low in state 4 before ready, the flag is set and the cycle still completes. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_ni | input | 1 | Stop-clock request from system logic, active low, may be asynchronous |
| retire_bnd_i | input | 1 | High in a cycle at an instruction retirement boundary |
| flush_req_o | output | 1 | Pipeline flush request |
| flush_done_i | input | 1 | Pipeline reports the flush is complete |
| bus_idle_i | input | 1 | No pending or in-progress bus cycle |
| ack_req_o | output | 1 | Request for the acknowledge special bus cycle |
| ack_rdy_i | input | 1 | Ready of the acknowledge special cycle |
| wbe_i | input | 1 | Write buffers empty |
| wbe_mask_i | input | 1 | High: write-buffer-empty is ignored when gating |
| bus_clk_stop_i | input | 1 | System logic has halted the bus clock |
| clk_en_o | output | 1 | Internal clock enable, low while gated |
| retire_en_o | output | 1 | Instruction retirement allowed |
| state_o | output | 3 | State code: 0 run, 1 recognized, 2 flush, 3 drain, 4 acknowledge, 5 stop-grant, 6 stop-clock |
| err_o | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest case to bring about is a minimum-width asynchronous request pulse. It must be caught at every phase relative to the clock, yet it ends before the sequence finishes. The bench places a pulse exactly two clock periods wide at five sub-cycle offsets, with the boundary strobe held high. It then expects recognition, followed by the violation flag. The gating point in the acknowledge state is swept over every ordering of ready and write-buffer-empty arrival within four cycles, with and without the mask. The expected dwell in that state is computed as one more than the larger of the two delays.

// File: rtl/stopclk_pkg.sv
`timescale 1ns/1ps
package stopclk_pkg;
  localparam int unsigned SC_STATE_W = 3;

  typedef enum logic [SC_STATE_W-1:0] {
    ST_RUN     = 3'd0,
    ST_RECOG   = 3'd1,
    ST_FLUSH   = 3'd2,
    ST_DRAIN   = 3'd3,
    ST_ACK     = 3'd4,
    ST_GRANT   = 3'd5,
    ST_STOPCLK = 3'd6
  } sc_state_e;
endpackage

// File: rtl/stopclk_sync.sv
`timescale 1ns/1ps
module stopclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/stopclk_ack_track.sv
`timescale 1ns/1ps
module stopclk_ack_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_ack_i,
  input  logic ack_rdy_i,
  input  logic wbe_i,
  input  logic wbe_mask_i,
  output logic ack_req_o,
  output logic gate_ok_o
);
  logic rdy_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdy_seen_q <= 1'b0;
    else if (!in_ack_i) rdy_seen_q <= 1'b0;
    else if (ack_rdy_i) rdy_seen_q <= 1'b1;
  end

  assign ack_req_o = in_ack_i && !rdy_seen_q;
  assign gate_ok_o = in_ack_i && (rdy_seen_q || ack_rdy_i) && (wbe_i || wbe_mask_i);
endmodule

// File: rtl/stopclk_fsm.sv
`timescale 1ns/1ps
module stopclk_fsm
  import stopclk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      retire_bnd_i,
  input  logic      flush_done_i,
  input  logic      bus_idle_i,
  input  logic      ack_open_i,
  input  logic      gate_ok_i,
  input  logic      bus_clk_stop_i,
  output sc_state_e state_o,
  output logic      resume_o,
  output logic      err_o
);
  sc_state_e state_q, state_d;
  logic pend_q, resume_q, err_q, viol;

  always_comb begin
    state_d = state_q;
    viol    = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (req_i && retire_bnd_i) state_d = ST_RECOG;
        viol = pend_q && !req_i;
      end
      ST_RECOG: begin
        if (!req_i) begin viol = 1'b1; state_d = ST_RUN; end
        else state_d = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (!req_i) begin viol = 1'b1; state_d = ST_RUN; end
        else if (flush_done_i) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!req_i) begin viol = 1'b1; state_d = ST_RUN; end
        else if (bus_idle_i) state_d = ST_ACK;
      end
      ST_ACK: begin
        viol = ack_open_i && !req_i;
        if (gate_ok_i) state_d = ST_GRANT;
      end
      ST_GRANT: begin
        if (bus_clk_stop_i) state_d = ST_STOPCLK;
        else if (!req_i)    state_d = ST_RUN;
      end
      ST_STOPCLK: begin
        if (!bus_clk_stop_i) state_d = ST_GRANT;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      pend_q   <= 1'b0;
      resume_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_q   <= (state_q == ST_RUN) && req_i && !retire_bnd_i;
      resume_q <= (state_q == ST_GRANT) && (state_d == ST_RUN);
      if (viol) err_q <= 1'b1;
    end
  end

  assign state_o  = state_q;
  assign resume_o = resume_q;
  assign err_o    = err_q;
endmodule

// File: rtl/stopclk_ctrl.sv
`timescale 1ns/1ps
module stopclk_ctrl
  import stopclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stop_req_ni,
  input  logic                  retire_bnd_i,
  output logic                  flush_req_o,
  input  logic                  flush_done_i,
  input  logic                  bus_idle_i,
  output logic                  ack_req_o,
  input  logic                  ack_rdy_i,
  input  logic                  wbe_i,
  input  logic                  wbe_mask_i,
  input  logic                  bus_clk_stop_i,
  output logic                  clk_en_o,
  output logic                  retire_en_o,
  output logic [SC_STATE_W-1:0] state_o,
  output logic                  err_o
);
  logic      req_s, gate_ok, resume, ack_open;
  sc_state_e state;

  stopclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (!stop_req_ni),
    .sync_o  (req_s)
  );

  stopclk_ack_track u_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_ack_i   (state == ST_ACK),
    .ack_rdy_i  (ack_rdy_i),
    .wbe_i      (wbe_i),
    .wbe_mask_i (wbe_mask_i),
    .ack_req_o  (ack_open),
    .gate_ok_o  (gate_ok)
  );

  stopclk_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req_s),
    .retire_bnd_i   (retire_bnd_i),
    .flush_done_i   (flush_done_i),
    .bus_idle_i     (bus_idle_i),
    .ack_open_i     (ack_open),
    .gate_ok_i      (gate_ok),
    .bus_clk_stop_i (bus_clk_stop_i),
    .state_o        (state),
    .resume_o       (resume),
    .err_o          (err_o)
  );

  assign ack_req_o   = ack_open;
  assign flush_req_o = (state == ST_FLUSH);
  assign clk_en_o    = !((state == ST_GRANT) || (state == ST_STOPCLK));
  assign retire_en_o = (state == ST_RUN) && !resume;
  assign state_o     = state;
endmodule

// File: rtl/stopclk_chk.sv
`timescale 1ns/1ps
module stopclk_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       retire_bnd_i,
  input logic       flush_done_i,
  input logic       wbe_i,
  input logic       wbe_mask_i,
  input logic       bus_clk_stop_i,
  input logic       ack_req_o,
  input logic       clk_en_o,
  input logic       retire_en_o,
  input logic [2:0] state_o,
  input logic       err_o
);
  p_recog_on_boundary_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1) |-> ($past(retire_bnd_i) && $past(state_o) == 3'd0));

  p_drain_after_flush_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2 && $past(flush_done_i)));

  p_ack_from_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> ($past(state_o) == 3'd3));

  p_grant_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && $past(state_o) == 3'd4) |-> ($past(wbe_i) || $past(wbe_mask_i)));

  p_stopclk_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6 && $past(state_o) != 3'd6) |-> ($past(state_o) == 3'd5 && $past(bus_clk_stop_i)));

  p_resume_clk_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && $past(state_o) == 3'd5) |-> (clk_en_o && !retire_en_o));

  p_resume_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && $past(state_o) == 3'd5) |=> (retire_en_o || state_o == 3'd1));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind stopclk_ctrl stopclk_chk i_chk (.*);

// File: tb/test_stopclk_ctrl.sv
`timescale 1ns/1ps
module test_stopclk_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1, retire_bnd = 1'b0, flush_done = 1'b0, bus_idle = 1'b0;
  logic ack_rdy = 1'b0, wbe = 1'b0, wbe_mask = 1'b0, bus_clk_stop = 1'b0;
  logic flush_req, ack_req, clk_en, retire_en, err;
  logic [2:0] state;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stopclk_ctrl i_stopclk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_ni(stop_req_n), .retire_bnd_i(retire_bnd),
    .flush_req_o(flush_req), .flush_done_i(flush_done), .bus_idle_i(bus_idle),
    .ack_req_o(ack_req), .ack_rdy_i(ack_rdy), .wbe_i(wbe), .wbe_mask_i(wbe_mask),
    .bus_clk_stop_i(bus_clk_stop), .clk_en_o(clk_en), .retire_en_o(retire_en),
    .state_o(state), .err_o(err)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stop_req_n = 1'b1; retire_bnd = 1'b0; flush_done = 1'b0;
    bus_idle = 1'b0; ack_rdy = 1'b0; wbe = 1'b0; wbe_mask = 1'b0; bus_clk_stop = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  // Drive a request through recognition, flush and drain into the acknowledge state.
  task automatic go_to_ack(input int bd);
    stop_req_n = 1'b0; retire_bnd = 1'b0;
    for (int i = 0; i < 2 + bd; i++) begin
      tick();
      chk(state == 3'd0 && retire_en, "R2 wait for boundary", state, 0);
    end
    retire_bnd = 1'b1; tick();
    chk(state == 3'd1 && !retire_en, "R2 recognized", state, 1);
    retire_bnd = 1'b0; bus_idle = 1'b1; tick();
    chk(state == 3'd2 && flush_req, "R3 flush", state, 2);
    repeat (2) tick();
    chk(state == 3'd2, "R4 idle bus does not skip flush", state, 2);
    flush_done = 1'b1; bus_idle = 1'b0; tick();
    chk(state == 3'd3 && !flush_req, "R4 drain", state, 3);
    flush_done = 1'b0; repeat (2) tick();
    chk(state == 3'd3, "R4 drain waits bus idle", state, 3);
    bus_idle = 1'b1; tick();
    chk(state == 3'd4 && ack_req, "R5 acknowledge", state, 4);
  endtask

  task automatic leave_grant();
    stop_req_n = 1'b1;
    repeat (2) tick();
    chk(state == 3'd5 && !clk_en, "R9 still granted while sync", state, 5);
    tick();
    chk(state == 3'd0 && clk_en && !retire_en, "R9 clock back first", {clk_en, retire_en}, 2);
    tick();
    chk(retire_en, "R9 retire next cycle", retire_en, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(state == 3'd0 && clk_en && retire_en && !flush_req && !ack_req && !err,
        "R1 reset", state, 0);
    // R3 flush-done outside the flush state
    flush_done = 1'b1; repeat (3) tick();
    chk(state == 3'd0 && !flush_req, "R3 flush_done ignored", state, 0);
    flush_done = 1'b0;

    // R6 R7 sweep of ready and write-buffer-empty arrival
    for (int mask = 0; mask < 2; mask++) begin
      for (int rd = 0; rd < 4; rd++) begin
        for (int wd = 0; wd < 4; wd++) begin
          int n, exp_n;
          if (mask == 1 && wd > 0) continue;
          do_reset();
          wbe_mask = mask[0];
          go_to_ack((rd + wd) % 3);
          n = 0;
          do begin
            ack_rdy = (n == rd);
            wbe = (mask == 1) ? 1'b0 : (n >= wd);
            tick();
            n++;
            if (state == 3'd4)
              chk(ack_req == (n <= rd), "R5 request held until ready", ack_req, n <= rd);
          end while (state == 3'd4 && n < 20);
          exp_n = ((mask == 1) ? rd : ((rd > wd) ? rd : wd)) + 1;
          chk(n == exp_n, mask ? "R7 mask ignores wbe" : "R6 gate timing", n, exp_n);
          chk(state == 3'd5 && !clk_en && !retire_en && !ack_req, "R6 stop-grant", state, 5);
          ack_rdy = 1'b0; wbe = 1'b0;
          leave_grant();
          chk(!err, "R10 no error on clean run", err, 0);
        end
      end
    end

    // R8 deep stop-clock
    do_reset();
    go_to_ack(0);
    wbe_mask = 1'b1; ack_rdy = 1'b1; tick();
    ack_rdy = 1'b0;
    chk(state == 3'd5, "R6 grant", state, 5);
    bus_clk_stop = 1'b1; tick();
    chk(state == 3'd6 && !clk_en, "R8 stop-clock", state, 6);
    stop_req_n = 1'b1; repeat (4) tick();
    chk(state == 3'd6, "R8 request ignored in stop-clock", state, 6);
    bus_clk_stop = 1'b0; tick();
    chk(state == 3'd5 && !clk_en, "R8 back to grant", state, 5);
    tick();
    chk(state == 3'd0 && clk_en && !retire_en, "R9 exit after clock restart", state, 0);

    // R2 R10 minimum-width asynchronous pulse at five phases
    for (int ph = 0; ph < 5; ph++) begin
      bit seen, acked;
      do_reset();
      retire_bnd = 1'b1;
      @(posedge clk); #(0.5 + ph);
      stop_req_n = 1'b0;
      #10;
      stop_req_n = 1'b1;
      seen = 1'b0; acked = 1'b0;
      for (int i = 0; i < 8; i++) begin
        tick();
        if (state == 3'd1) seen = 1'b1;
        if (ack_req) acked = 1'b1;
      end
      chk(seen, "R2 two-clock pulse captured", seen, 1);
      chk(err && !acked && state == 3'd0, "R10 early drop aborts", {err, acked}, 2);
    end

    // R10 drop while pending before a boundary
    do_reset();
    stop_req_n = 1'b0; repeat (4) tick();
    stop_req_n = 1'b1; repeat (4) tick();
    chk(err && state == 3'd0 && !ack_req, "R10 pending drop", err, 1);
    repeat (5) tick();
    chk(err, "R10 flag sticky", err, 1);

    // R10 drop during acknowledge before ready
    do_reset();
    go_to_ack(1);
    stop_req_n = 1'b1; repeat (4) tick();
    chk(err && state == 3'd4 && ack_req, "R10 drop in acknowledge", {err, state}, 12);
    wbe_mask = 1'b1; ack_rdy = 1'b1; tick();
    ack_rdy = 1'b0;
    chk(state == 3'd5, "R10 cycle completes", state, 5);
    tick();
    chk(state == 3'd0 && err, "R10 returns to run", state, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule